// File: doc/BRIEF.md
# GPIO Pin Interrupt Slot Bank

This block turns selected general-purpose input pins into interrupt requests. It holds a bank of slots. Each slot picks one pin out of the GPIO input vector by a source index, watches it for a programmable trigger (rising edge, falling edge, high level or low level), and latches a pending bit when the trigger occurs while the slot is switched on. Every slot drives its own active-high level request to a parent interrupt controller for as long as its pending bit is set and the slot is enabled.

Software programs the bank through a simple 32-bit register bus with separate write and read strobes. Three groups of registers are exposed. Slot configuration bytes carry the pin index and an enable flag. Two trigger-mode registers carry two bits per slot. A pending register holds one bit per slot, and software acknowledges a slot by writing 0 to its bit. Pad logic and the parent controller are outside the block.

Top module: `gpio_irq_slots`

## Requirements
- R1: After reset every register reads 0, so all slots are disabled in rising-edge mode, no bit is pending, and slot_req is all zeros.
- R2: Slot n's configuration byte is at address 0x30 + 4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). In that byte, bit 7 enables the slot and bits 6:0 hold the pin index. A written register reads back unchanged.
- R3: Slots 0 to 15 take their trigger mode from address 0x24 and slots 16 to 31 from address 0x28, at bits 2*(n%16)+1 down to 2*(n%16). The codes are 0 rising edge, 1 falling edge, 2 high level and 3 low level. A written register reads back unchanged.
- R4: In rising mode, an enabled slot sets its pending bit on the clock edge after its pin goes from 0 to 1. The bit stays set after the pin returns low, and a pin that stays high does not set it again.
- R5: In falling mode, an enabled slot sets its pending bit only on a 1-to-0 transition of its pin. A rising transition has no effect.
- R6: In high-level or low-level mode, the pending bit is set on every clock edge while the selected level is present, so a clear written during that level leaves the bit set.
- R7: The pending register is at address 0x20, with slot n at bit n. Writing 0 to a bit clears it. Writing 1 leaves it unchanged.
- R8: When a trigger and a clearing write to the same slot fall on the same clock edge, the pending bit ends up set.
- R9: A disabled slot never sets its pending bit. Its pin history is still tracked, so enabling a slot in rising mode while its pin is already high does not set the bit.
- R10: A pin index at or above NUM_PINS selects a constant 0. High-level mode therefore never fires, and low-level mode always fires.
- R11: slot_req[n] is a register loaded on each edge with the new pending bit AND the slot's enable. It rises on the same edge as the pending bit and falls on the edge after a clear or after the slot is disabled. Disabling a slot keeps its pending bit.
- R12: Read data appears on bus_rdata one clock after a read strobe and holds until the next read. Addresses outside the mapped registers read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| gpio_in | input | NUM_PINS (100) | Synchronised GPIO pin levels |
| slot_req | output | NUM_SLOTS (32) | Per-slot active-high level request |

## Verification
Two things can happen to a pending bit on the same edge: a trigger that sets it, and a software write of 0 that clears it. The bench causes this collision on purpose in two ways. In the first, it drives a rising pin transition in the same cycle as the clearing write. In the second, it writes the clear while a slot in level mode still sees its active level. In both cases the bench reads the pending register afterwards and expects the bit still set. A second clear, written once the cause has gone, must then leave the bit at 0.

// File: rtl/gis_pkg.sv
`timescale 1ns/1ps
package gis_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_e;

  localparam int FIELD_W     = 8;
  localparam int TRIG_W      = 2;
  localparam int ADDR_STATUS = 'h20;
  localparam int ADDR_TRIG0  = 'h24;
  localparam int ADDR_SEL0   = 'h30;

endpackage

// File: rtl/gis_regfile.sv
`timescale 1ns/1ps
module gis_regfile
  import gis_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = 7,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr,
  input  logic                             rd,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [NUM_SLOTS-1:0]             status,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_SLOTS-1:0]             slot_en,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]  slot_idx,
  output logic [NUM_SLOTS-1:0][TRIG_W-1:0] slot_trig,
  output logic [NUM_SLOTS-1:0]             clr_mask
);

  localparam int PER_SEL  = DATA_W / FIELD_W;
  localparam int PER_TRIG = DATA_W / TRIG_W;
  localparam int NUM_SEL  = (NUM_SLOTS + PER_SEL - 1) / PER_SEL;
  localparam int NUM_TRIG = (NUM_SLOTS + PER_TRIG - 1) / PER_TRIG;
  localparam int EN_BIT   = FIELD_W - 1;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(ADDR_STATUS);

  logic [DATA_W-1:0] sel_q  [NUM_SEL];
  logic [DATA_W-1:0] trig_q [NUM_TRIG];
  logic [DATA_W-1:0] rd_next;

  // Configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEL; i++)  sel_q[i]  <= '0;
      for (int i = 0; i < NUM_TRIG; i++) trig_q[i] <= '0;
    end else if (wr) begin
      for (int i = 0; i < NUM_SEL; i++)
        if (addr == ADDR_W'(ADDR_SEL0 + 4 * i)) sel_q[i] <= wdata;
      for (int i = 0; i < NUM_TRIG; i++)
        if (addr == ADDR_W'(ADDR_TRIG0 + 4 * i)) trig_q[i] <= wdata;
    end
  end

  // Clear strobes: a 0 written to the pending register clears that slot
  assign clr_mask = (wr && addr == STAT_A) ? ~wdata[NUM_SLOTS-1:0] : '0;

  // Read path
  always_comb begin
    rd_next = '0;
    if (addr == STAT_A) rd_next = DATA_W'(status);
    for (int i = 0; i < NUM_TRIG; i++)
      if (addr == ADDR_W'(ADDR_TRIG0 + 4 * i)) rd_next = trig_q[i];
    for (int i = 0; i < NUM_SEL; i++)
      if (addr == ADDR_W'(ADDR_SEL0 + 4 * i)) rd_next = sel_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_next;
  end

  // Per-slot field extraction
  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_unpack
    localparam int SR = n / PER_SEL;
    localparam int SB = FIELD_W * (n % PER_SEL);
    localparam int TR = n / PER_TRIG;
    localparam int TB = TRIG_W * (n % PER_TRIG);
    assign slot_en[n]   = sel_q[SR][SB + EN_BIT];
    assign slot_idx[n]  = sel_q[SR][SB +: IDX_W];
    assign slot_trig[n] = trig_q[TR][TB +: TRIG_W];
  end

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/gis_slot.sv
`timescale 1ns/1ps
module gis_slot
  import gis_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int PIN_SPACE = 128,
  parameter int NUM_PINS  = 100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_SPACE-1:0] pins,
  input  logic                 en,
  input  logic [IDX_W-1:0]     idx,
  input  trig_e                trig,
  input  logic                 clr,
  output logic                 status_q,
  output logic                 req_q
);

  localparam logic [IDX_W:0] PIN_LIMIT = (IDX_W + 1)'(NUM_PINS);

  logic in_range, sel_pin, prev_q, hit, status_d;

  assign in_range = {1'b0, idx} < PIN_LIMIT;
  assign sel_pin  = in_range & pins[idx];

  always_comb begin
    unique case (trig)
      TRIG_RISE: hit = sel_pin & ~prev_q;
      TRIG_FALL: hit = ~sel_pin & prev_q;
      TRIG_HIGH: hit = sel_pin;
      TRIG_LOW:  hit = ~sel_pin;
      default:   hit = 1'b0;
    endcase
  end

  // A trigger outranks a clearing write on the same edge
  always_comb begin
    if (en && hit) status_d = 1'b1;
    else if (clr)  status_d = 1'b0;
    else           status_d = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      prev_q   <= sel_pin;
      status_q <= status_d;
      req_q    <= status_d & en;
    end
  end

  assert_disabled_no_set_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !status_q) |=> !status_q);

  assert_req_needs_pending_R11: assert property (@(posedge clk) disable iff (rst)
    req_q |-> status_q);

  assert_level_persists_R6: assert property (@(posedge clk) disable iff (rst)
    (en && trig == TRIG_HIGH && sel_pin) |=> status_q);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (en && hit && clr) |=> status_q);

  assert_out_of_range_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (en && !in_range && trig == TRIG_HIGH && !status_q) |=> !status_q);

endmodule

// File: rtl/gpio_irq_slots.sv
`timescale 1ns/1ps
module gpio_irq_slots
  import gis_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_PINS  = 100,
  parameter int IDX_W     = 7,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0]  gpio_in,
  output logic [NUM_SLOTS-1:0] slot_req
);

  localparam int PIN_SPACE = 1 << IDX_W;

  logic [PIN_SPACE-1:0]              pins_pad;
  logic [NUM_SLOTS-1:0]              slot_en, clr_mask, status;
  logic [NUM_SLOTS-1:0][IDX_W-1:0]   slot_idx;
  logic [NUM_SLOTS-1:0][TRIG_W-1:0]  slot_trig;

  assign pins_pad = PIN_SPACE'(gpio_in);

  gis_regfile #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(status), .rdata(bus_rdata),
    .slot_en(slot_en), .slot_idx(slot_idx), .slot_trig(slot_trig),
    .clr_mask(clr_mask)
  );

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    gis_slot #(
      .IDX_W(IDX_W), .PIN_SPACE(PIN_SPACE), .NUM_PINS(NUM_PINS)
    ) u_slot (
      .clk(clk), .rst(rst), .pins(pins_pad), .en(slot_en[n]),
      .idx(slot_idx[n]), .trig(trig_e'(slot_trig[n])), .clr(clr_mask[n]),
      .status_q(status[n]), .req_q(slot_req[n])
    );
  end

endmodule

// File: tb/sim_gpio_irq_slots.sv
`timescale 1ns/1ps
module sim_gpio_irq_slots;

  localparam int NP = 100;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [NS-1:0] slot_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_slots u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .slot_req(slot_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic apply_reset();
    rst = 1'b1; gpio_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    apply_reset();
    check("R1 req after reset", 32'(slot_req), 32'h0);
    bus_read(8'h20, d); check("R1 pending", d, 32'h0);
    bus_read(8'h24, d); check("R1 mode lo", d, 32'h0);
    bus_read(8'h28, d); check("R1 mode hi", d, 32'h0);
    for (int i = 0; i < 8; i++) begin
      bus_read(8'(8'h30 + 4 * i), d); check("R1 select", d, 32'h0);
    end
  endtask

  task automatic t_layout();
    logic [31:0] d;
    apply_reset();
    bus_write(8'h34, 32'h8A05837F);
    bus_read(8'h34, d); check("R2 select readback", d, 32'h8A05837F);
    bus_write(8'h28, 32'hDEADBEEF);
    bus_read(8'h28, d); check("R3 mode readback", d, 32'hDEADBEEF);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    apply_reset();
    bus_write(8'h34, 32'h0000_9400);        // slot 5: enabled, pin 20
    tick();
    gpio_in[20] = 1'b1; tick();
    check("R4 R11 req on rise", 32'(slot_req), 32'h20);
    bus_read(8'h20, d); check("R4 pending on rise", d, 32'h20);
    gpio_in[20] = 1'b0; tick(); tick();
    bus_read(8'h20, d); check("R4 pending held", d, 32'h20);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, d); check("R7 ones no effect", d, 32'h20);
    bus_write(8'h20, ~32'h20);
    bus_read(8'h20, d); check("R7 zero clears", d, 32'h0);
    check("R11 req falls after clear", 32'(slot_req), 32'h0);
    gpio_in[20] = 1'b1; tick();
    bus_write(8'h20, ~32'h20);
    tick(); tick();
    bus_read(8'h20, d); check("R4 steady high no re-set", d, 32'h0);
  endtask

  task automatic t_falling();
    apply_reset();
    gpio_in[60] = 1'b1;
    bus_write(8'h28, 32'h0000_0004);        // slot 17 falling
    bus_write(8'h40, 32'h0000_BC00);        // slot 17: enabled, pin 60
    tick();
    check("R5 no fall yet", 32'(slot_req), 32'h0);
    gpio_in[60] = 1'b0; tick();
    check("R5 fall sets", 32'(slot_req), 32'h0002_0000);
    bus_write(8'h20, ~32'h0002_0000);
    gpio_in[60] = 1'b1; tick(); tick();
    check("R5 rise ignored", 32'(slot_req), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    apply_reset();
    bus_write(8'h28, 32'h2000_0000);        // slot 30 high level
    bus_write(8'h4C, 32'h00DA_0000);        // slot 30: enabled, pin 90
    gpio_in[90] = 1'b1; tick();
    check("R6 high level sets", 32'(slot_req), 32'h4000_0000);
    bus_write(8'h20, ~32'h4000_0000);
    bus_read(8'h20, d); check("R6 R8 level resets after clear", d, 32'h4000_0000);
    gpio_in[90] = 1'b0; tick();
    bus_write(8'h20, ~32'h4000_0000);
    bus_read(8'h20, d); check("R6 clear once level gone", d, 32'h0);
    bus_write(8'h28, 32'h3000_0000);        // low level
    tick();
    check("R6 low level sets", 32'(slot_req), 32'h4000_0000);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    apply_reset();
    bus_write(8'h34, 32'h0000_9400);
    tick();
    gpio_in[20] = 1'b1;
    bus_addr = 8'h20; bus_wdata = ~32'h20; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
    bus_read(8'h20, d); check("R8 edge beats clear", d, 32'h20);
    bus_write(8'h20, ~32'h20);
    bus_read(8'h20, d); check("R8 later clear works", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    apply_reset();
    bus_write(8'h30, 32'h0000_0003);        // slot 0 pin 3, disabled
    gpio_in[3] = 1'b1; tick(); tick();
    check("R9 disabled req", 32'(slot_req), 32'h0);
    bus_read(8'h20, d); check("R9 disabled pending", d, 32'h0);
    bus_write(8'h30, 32'h0000_0083);
    tick(); tick();
    bus_read(8'h20, d); check("R9 no false edge on enable", d, 32'h0);
    gpio_in[3] = 1'b0; tick();
    gpio_in[3] = 1'b1; tick();
    check("R9 fresh edge after enable", 32'(slot_req), 32'h1);
    bus_write(8'h30, 32'h0000_0003);
    tick();
    check("R11 req drops on disable", 32'(slot_req), 32'h0);
    bus_read(8'h20, d); check("R11 pending kept on disable", d, 32'h1);
  endtask

  task automatic t_out_of_range();
    apply_reset();
    gpio_in = '1;
    bus_write(8'h24, 32'h0008_0000);        // slot 9 high level
    bus_write(8'h38, 32'h0000_F800);        // slot 9: enabled, pin 120
    tick(); tick();
    check("R10 high never fires", 32'(slot_req), 32'h0);
    bus_write(8'h24, 32'h000C_0000);        // low level
    tick();
    check("R10 low always fires", 32'(slot_req), 32'h0000_0200);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    apply_reset();
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h2C, 32'hFFFF_FFFF);
    bus_read(8'h00, d); check("R12 unmapped 0x00", d, 32'h0);
    bus_read(8'h2C, d); check("R12 unmapped 0x2C", d, 32'h0);
    bus_read(8'h50, d); check("R12 unmapped 0x50", d, 32'h0);
    bus_write(8'h24, 32'h1234_5678);
    bus_read(8'h24, d);
    bus_addr = 8'h00; tick(); tick();
    check("R12 rdata holds", bus_rdata, 32'h1234_5678);
  endtask

  initial begin
    t_reset_state();
    t_layout();
    t_rising();
    t_falling();
    t_level();
    t_collide();
    t_disabled();
    t_out_of_range();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule